// File: doc/BRIEF.md
# Shared-Adder Integer ALU

This block is a purely combinational arithmetic logic unit for a 32-bit integer datapath. It takes two operands and a 4-bit operation select, and returns a 32-bit result together with a flag that is high when that result is all zeros. It supports addition, subtraction, signed set-less-than, and four bitwise functions: and, or, xor and nor.

The operation select is a sparse code, and its bits drive the datapath multiplexers directly, with no decode stage. Bit 2 chooses between the logic unit and the arithmetic unit. Bit 1 turns the single adder into a subtractor by inverting the second operand and forcing a carry-in of one. Bit 3 replaces the arithmetic output with the zero-extended sign bit of the difference. Codes outside the defined set give an unspecified result, and the surrounding pipeline must ignore it. The adder keeps no carry-out or overflow, and set-less-than uses the raw sign of the difference without any overflow correction.

Top module: `shared_adder_alu`

## Requirements
- R1: Select code 4'b0000 gives `alu_result` = `operand_a` + `operand_b`, wrapped modulo 2^32 (the carry-out is dropped).
- R2: Select code 4'b0010 gives `alu_result` = `operand_a` − `operand_b`, wrapped modulo 2^32.
- R3: Select code 4'b1010 gives bit 31 of (`operand_a` − `operand_b`) in result bit 0, with bits 31:1 equal to zero. Signed overflow is not corrected: A=32'h8000_0000 with B=32'h0000_0001 gives 0.
- R4: Select codes 4'b0100, 4'b0101, 4'b0110 and 4'b0111 give the bitwise and, or, xor and nor of the two operands, in that order.
- R5: `result_zero` is 1 exactly when all 32 bits of `alu_result` are 0, for every defined select code.
- R6: When the operands are equal, subtract gives 0 with `result_zero` = 1, and set-less-than gives 0 with `result_zero` = 1.
- R7: Outputs are combinational. A change of an input appears on the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation select: bit 3 = set-less-than pick, bit 2 = logic path, bit 1 = subtract / logic function high bit, bit 0 = logic function low bit |
| operand_a | input | 32 | First operand |
| operand_b | input | 32 | Second operand |
| alu_result | output | 32 | Selected result |
| result_zero | output | 1 | High when alu_result is all zeros |

## Verification
Immediate assertions check on every input change that the adder output is consistent with its operands for both add and subtract, and that equal operands give a zero difference. They also check that the xor and nor outputs relate correctly to their inputs, that set-less-than never drives any bit above bit 0, and that complementary operands under and raise the zero flag. The exact wrapping values, the uncorrected sign at signed-overflow corners, and the full mapping of each select code to its function can only be shown by the bench. The bench compares each defined code against an independent reference, using corner operands and seeded random operands.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned SEL_W  = 4;

    // Defined select codes; the positions of bits are part of the behaviour
    localparam logic [SEL_W-1:0] SEL_ADD = 4'b0000;
    localparam logic [SEL_W-1:0] SEL_SUB = 4'b0010;
    localparam logic [SEL_W-1:0] SEL_AND = 4'b0100;
    localparam logic [SEL_W-1:0] SEL_OR  = 4'b0101;
    localparam logic [SEL_W-1:0] SEL_XOR = 4'b0110;
    localparam logic [SEL_W-1:0] SEL_NOR = 4'b0111;
    localparam logic [SEL_W-1:0] SEL_SLT = 4'b1010;

    typedef enum logic [1:0] {
        LFN_AND = 2'b00,
        LFN_OR  = 2'b01,
        LFN_XOR = 2'b10,
        LFN_NOR = 2'b11
    } logic_fn_e;

    // Control view of the select code: fields map one-to-one on its bits
    typedef struct packed {
        logic      sign_pick;   // bit 3
        logic      logic_path;  // bit 2
        logic_fn_e fn;          // bits 1:0 (bit 1 doubles as subtract enable)
    } alu_ctrl_t;

    function automatic alu_ctrl_t split_sel(input logic [SEL_W-1:0] sel);
        alu_ctrl_t c;
        c.sign_pick  = sel[3];
        c.logic_path = sel[2];
        c.fn         = logic_fn_e'(sel[1:0]);
        return c;
    endfunction

    function automatic logic sub_enable(input alu_ctrl_t c);
        return c.fn[1];
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned WIDTH = alu_pkg::DATA_W
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] cin_vec;

    always_comb begin
        b_eff   = b ^ {WIDTH{sub}};
        cin_vec = {{(WIDTH-1){1'b0}}, sub};
        sum     = a + b_eff + cin_vec;
    end

    always_comb begin
        if (!$isunknown({a, b, sub})) begin
            if (!sub) begin
                AST_ADD_INVERSE: assert ((sum - b) == a) else $error("add inverse broken"); // R1
            end else begin
                AST_SUB_INVERSE: assert ((sum + b) == a) else $error("sub inverse broken"); // R2
                if (a == b) begin
                    AST_SELF_DIFF_ZERO: assert (sum == '0) else $error("a-a not zero"); // R6
                end
            end
        end
    end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
    parameter int unsigned WIDTH = alu_pkg::DATA_W
) (
    input  logic [WIDTH-1:0]     a,
    input  logic [WIDTH-1:0]     b,
    input  alu_pkg::logic_fn_e   fn,
    output logic [WIDTH-1:0]     y
);
    import alu_pkg::*;

    always_comb begin
        unique case (fn)
            LFN_AND: y = a & b;
            LFN_OR:  y = a | b;
            LFN_XOR: y = a ^ b;
            LFN_NOR: y = ~(a | b);
            default: y = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({a, b, fn})) begin
            if (fn == LFN_XOR) begin
                AST_XOR_RECOVERS: assert ((y ^ a) == b) else $error("xor relation broken"); // R4
            end
            if (fn == LFN_NOR) begin
                AST_NOR_DISJOINT: assert ((y & (a | b)) == '0) else $error("nor overlaps inputs"); // R4
            end
            if (fn == LFN_AND) begin
                AST_AND_SUBSET: assert ((y & ~a) == '0) else $error("and outside a"); // R4
            end
        end
    end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int unsigned WIDTH = alu_pkg::DATA_W,
    parameter int unsigned CHUNK = 8
) (
    input  logic [WIDTH-1:0] data,
    output logic             is_zero
);
    localparam int unsigned NCHUNK = (WIDTH + CHUNK - 1) / CHUNK;
    localparam int unsigned PADW   = NCHUNK * CHUNK;

    logic [PADW-1:0]   padded;
    logic [NCHUNK-1:0] chunk_any;

    always_comb begin
        padded = '0;
        padded[WIDTH-1:0] = data;
    end

    for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
        assign chunk_any[g] = |padded[g*CHUNK +: CHUNK];
    end

    assign is_zero = ~|chunk_any;
endmodule

// File: rtl/shared_adder_alu.sv
module shared_adder_alu #(
    parameter int unsigned WIDTH = alu_pkg::DATA_W
) (
    input  logic [alu_pkg::SEL_W-1:0] op_sel,
    input  logic [WIDTH-1:0]          operand_a,
    input  logic [WIDTH-1:0]          operand_b,
    output logic [WIDTH-1:0]          alu_result,
    output logic                      result_zero
);
    import alu_pkg::*;

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] arith_sum;
    logic [WIDTH-1:0] arith_out;
    logic [WIDTH-1:0] logic_out;

    assign ctrl = split_sel(op_sel);

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a   (operand_a),
        .b   (operand_b),
        .sub (sub_enable(ctrl)),
        .sum (arith_sum)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a  (operand_a),
        .b  (operand_b),
        .fn (ctrl.fn),
        .y  (logic_out)
    );

    always_comb begin
        if (ctrl.sign_pick)
            arith_out = {{(WIDTH-1){1'b0}}, arith_sum[WIDTH-1]};
        else
            arith_out = arith_sum;
        alu_result = ctrl.logic_path ? logic_out : arith_out;
    end

    alu_zero_detect #(.WIDTH(WIDTH), .CHUNK(8)) u_zero (
        .data    (alu_result),
        .is_zero (result_zero)
    );

    always_comb begin
        if (!$isunknown({op_sel, operand_a, operand_b})) begin
            if (op_sel == SEL_SLT) begin
                AST_SLT_ONE_BIT: assert (alu_result[WIDTH-1:1] == '0) else $error("slt upper bits set"); // R3
            end
            if (op_sel == SEL_AND && operand_a == ~operand_b) begin
                AST_DISJOINT_AND_ZERO: assert (result_zero) else $error("zero flag missed"); // R5
            end
            if (op_sel == SEL_OR && operand_a != '0) begin
                AST_OR_NONZERO_FLAG: assert (!result_zero) else $error("zero flag false"); // R5
            end
        end
    end
endmodule

// File: tb/test_shared_adder_alu.sv
module test_shared_adder_alu;
    logic        clk = 1'b0;
    logic [3:0]  op_sel;
    logic [31:0] operand_a, operand_b;
    logic [31:0] alu_result;
    logic        result_zero;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    shared_adder_alu i_shared_adder_alu (
        .op_sel      (op_sel),
        .operand_a   (operand_a),
        .operand_b   (operand_b),
        .alu_result  (alu_result),
        .result_zero (result_zero)
    );

    function automatic logic [31:0] ref_model(input logic [3:0] s, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] d;
        d = a - b;
        case (s)
            4'b0000: return a + b;
            4'b0010: return d;
            4'b0100: return a & b;
            4'b0101: return a | b;
            4'b0110: return a ^ b;
            4'b0111: return ~(a | b);
            4'b1010: return {31'd0, d[31]};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s sel=%b a=%h b=%h got=%h exp=%h", req, op_sel, operand_a, operand_b, got, exp);
        end
    endtask

    // Apply at falling edge, sample before the next rising edge
    task automatic apply_and_check(input string req, input logic [3:0] s, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] e;
        @(negedge clk);
        op_sel = s; operand_a = a; operand_b = b;
        #1;
        e = ref_model(s, a, b);
        check(req, alu_result, e);
        check({req, "/R5"}, {31'd0, result_zero}, {31'd0, e == 32'd0});
    endtask

    task automatic t_idle;
        @(negedge clk);
        op_sel = 4'b0000; operand_a = '0; operand_b = '0;
        #1;
        check("R1 idle", alu_result, 32'd0);
        check("R5 idle", {31'd0, result_zero}, 32'd1);
    endtask

    task automatic t_add;
        apply_and_check("R1", 4'b0000, 32'h0000_0003, 32'h0000_0004);
        check("R1 value", alu_result, 32'h0000_0007);
        apply_and_check("R1 wrap", 4'b0000, 32'hFFFF_FFFF, 32'h0000_0001);
        check("R1 wrap value", alu_result, 32'h0000_0000);
        apply_and_check("R1", 4'b0000, 32'h7FFF_FFFF, 32'h0000_0001);
        check("R1 value", alu_result, 32'h8000_0000);
    endtask

    task automatic t_sub;
        apply_and_check("R2", 4'b0010, 32'h0000_0010, 32'h0000_0003);
        check("R2 value", alu_result, 32'h0000_000D);
        apply_and_check("R2 wrap", 4'b0010, 32'h0000_0000, 32'h0000_0001);
        check("R2 wrap value", alu_result, 32'hFFFF_FFFF);
        apply_and_check("R6 sub equal", 4'b0010, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        check("R6 sub zero flag", {31'd0, result_zero}, 32'd1);
    endtask

    task automatic t_slt;
        apply_and_check("R3 less", 4'b1010, 32'hFFFF_FFFF, 32'h0000_0001);
        check("R3 less value", alu_result, 32'd1);
        apply_and_check("R3 greater", 4'b1010, 32'h0000_0005, 32'hFFFF_FFFE);
        check("R3 greater value", alu_result, 32'd0);
        apply_and_check("R3 no overflow fix", 4'b1010, 32'h8000_0000, 32'h0000_0001);
        check("R3 no overflow fix value", alu_result, 32'd0);
        apply_and_check("R3 no overflow fix2", 4'b1010, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        check("R3 no overflow fix2 value", alu_result, 32'd1);
        apply_and_check("R6 slt equal", 4'b1010, 32'h1234_5678, 32'h1234_5678);
        check("R6 slt zero flag", {31'd0, result_zero}, 32'd1);
    endtask

    task automatic t_logic;
        apply_and_check("R4 and", 4'b0100, 32'hF0F0_FF00, 32'hFF00_F0F0);
        check("R4 and value", alu_result, 32'hF000_F000);
        apply_and_check("R4 or",  4'b0101, 32'hF0F0_0000, 32'h0F00_000F);
        check("R4 or value", alu_result, 32'hFFF0_000F);
        apply_and_check("R4 xor", 4'b0110, 32'hAAAA_5555, 32'hFFFF_0000);
        check("R4 xor value", alu_result, 32'h5555_5555);
        apply_and_check("R4 nor", 4'b0111, 32'h0000_0000, 32'h0000_0000);
        check("R4 nor value", alu_result, 32'hFFFF_FFFF);
        apply_and_check("R5 and disjoint", 4'b0100, 32'h5555_5555, 32'hAAAA_AAAA);
        check("R5 and disjoint flag", {31'd0, result_zero}, 32'd1);
        apply_and_check("R5 nor all ones", 4'b0111, 32'hFFFF_FFFF, 32'h0000_0000);
    endtask

    task automatic t_corners;
        logic [31:0] vals [5] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001};
        logic [3:0]  sels [7] = '{4'b0000, 4'b0010, 4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1010};
        foreach (sels[s])
            foreach (vals[i])
                foreach (vals[j])
                    apply_and_check("R1/R2/R3/R4 corner", sels[s], vals[i], vals[j]);
    endtask

    task automatic t_random;
        logic [3:0] sels [7] = '{4'b0000, 4'b0010, 4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1010};
        void'($urandom(32'h5EED));
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a, b;
            a = $urandom();
            b = (n % 10 == 0) ? a : $urandom();
            apply_and_check("R1/R2/R3/R4 random", sels[n % 7], a, b);
        end
    endtask

    // Input change visible with no clock edge in between
    task automatic t_comb;
        @(posedge clk);
        #0.5;
        op_sel = 4'b0000; operand_a = 32'd10; operand_b = 32'd20;
        #0.5;
        check("R7 same-phase", alu_result, 32'd30);
        operand_b = 32'd21;
        #0.5;
        check("R7 same-phase", alu_result, 32'd31);
    endtask

    initial begin
        t_idle();
        t_add();
        t_sub();
        t_slt();
        t_logic();
        t_comb();
        t_corners();
        t_random();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule